// File: doc/BRIEF.md
# Dual-Channel Storage Controller Register Bank

This block is the register file and interrupt logic of a two-channel storage host controller. Software reaches it through a simple request bus carrying a 9-bit byte offset, a transfer size of 1, 2 or 4 bytes, and 32-bit write data. Reads return one cycle later with a valid strobe. For each channel the bank holds a DMA command byte, a DMA status byte, a 32-bit descriptor table address, a 6-bit scratch byte, a configuration/status word, a 12-bit link-control word and a 16-bit interrupt-enable field.

The DMA engine reports to the bank with a busy level and two set pulses (error and interrupt) per channel. The drive side reports one interrupt level and one device-present level per channel. The bank registers the interrupt levels into the configuration/status words, ORs them onto a single interrupt output, and gives one-cycle channel-reset pulses when software writes link control with bit 0 set. Two summary words at offsets 0x10 and 0x18 let software read command, status and pending interrupt bits with a single access.

Top module: `dual_chan_regbank`

## Requirements
- R1: After reset, command, status, table address, scratch, link-control and interrupt-enable registers read 0, each configuration/status word reads 0x65150000, and rsp_valid is low.
- R2: A read request returns its data on rsp_rdata with rsp_valid high exactly one cycle later. A write produces no response. Unmapped offsets read 0 and writes to them have no effect.
- R3: Channel c DMA bytes sit at offset 8c: +0 command (8 bits), +1 scratch (keeps only bits 5:0), +2 status, +3 reads 0, +4..+7 table address. Byte registers take req_wdata[7:0]. A table-address access at +4+k uses req_size 0/1/2 for 1/2/4 bytes. Data bit 8j+7:8j goes to address byte k+j, and bytes past +7 are dropped. A read at +4+k returns the address shifted right by 8k bits.
- R4: Writes to command, scratch and status are also accepted at their offset plus 0x10. Reads at those mirror offsets, apart from 0x10 and 0x18, return 0.
- R5: A status write loads bits 6:5 from the data and clears bit 1 or bit 2 where the data bit is 1. It leaves bit 0 unchanged and forces bits 7, 4 and 3 to 0.
- R6: Status bit 0 follows the channel's dma_busy input one cycle later. An error or interrupt set pulse sets bit 1 or bit 2 one cycle later, and a set wins over a same-cycle clearing write.
- R7: The configuration/status word (channel 0 at 0xA0, channel 1 at 0xE0) shows the channel's interrupt input in bit 11 one cycle after it changes. Writes to this word are ignored.
- R8: irq_out is high exactly when bit 11 is set in either configuration/status word.
- R9: A read at 0x10 returns channel 0 command in bits 7:0, ORed with channel 0 pending in bit 4, channel 1 pending in bit 6 and channel 1 status bit 2 in bit 14, with channel 0 status in bits 23:16 and channel 1 status in bits 31:24.
- R10: A read at 0x18 returns channel 1 command, ORed with channel 1 pending in bit 4, and channel 1 status in bits 23:16.
- R11: Link control (0x100, 0x180) keeps only data bits 11:0. A write with data bit 0 set drives that channel's chan_reset high for exactly the next cycle.
- R12: Interrupt enable (0x148, 0x1C8) loads data bits 31:16 masked with 0x3EED and reads back in bits 31:16.
- R13: Link status (0x104, 0x184) reads 0x113 when that channel's dev_present is high and 0 when it is low.
- R14: Both chan_reset bits are high while reset is applied and for the first cycle after it is released, then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 9 | Byte offset |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| dma_busy | input | 2 | Per-channel DMA busy level |
| dma_err_set | input | 2 | Per-channel error set pulse |
| dma_int_set | input | 2 | Per-channel DMA interrupt set pulse |
| chan_irq_in | input | 2 | Per-channel interrupt level |
| dev_present | input | 2 | Per-channel device-present level |
| irq_out | output | 1 | Combined interrupt |
| chan_reset | output | 2 | Per-channel reset pulse |

## Verification
Two collisions matter. The first is a write-one-to-clear status write in the same cycle as a DMA set pulse for the same bit. The bench drives both on one clock edge, then reads status back and expects the bit still set. The second is a summary read at 0x10 in the same cycle as a rising interrupt input. The bench expects that read to show the old pending bit and the next read to show the new one, since the read samples registered state.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int OFF_W       = 9;
  localparam int DW          = 32;
  localparam int NUM_CH      = 2;
  localparam int DMA_STRIDE  = 8;
  localparam int MIRROR_GAP  = 16;
  localparam int CONF_BASE   = 'hA0;
  localparam int CONF_STRIDE = 'h40;
  localparam int LINK_BASE   = 'h100;
  localparam int LINK_STRIDE = 'h80;
  localparam int LSTAT_REL   = 'h4;
  localparam int IEN_REL     = 'h48;
  localparam int SUM0_OFF    = 'h10;
  localparam int SUM1_OFF    = 'h18;
  localparam int LCTL_W      = 12;
  localparam int IEN_W       = 16;
  localparam logic [15:0] CONF_HI_RST  = 16'h6515;
  localparam logic [15:0] IEN_MASK     = 16'h3EED;
  localparam logic [7:0]  SCRATCH_MASK = 8'h3F;
  localparam logic [DW-1:0] LINK_UP    = 32'h113;
  localparam int IRQ_BIT = 11;

  // Status byte after a software write: 6:5 loaded, 2:1 write-one-to-clear, 0 kept.
  function automatic logic [7:0] status_after_write(logic [7:0] old, logic [7:0] wd);
    logic [7:0] r;
    r      = 8'h00;
    r[6:5] = wd[6:5];
    r[2:1] = old[2:1] & ~wd[2:1];
    r[0]   = old[0];
    return r;
  endfunction

  function automatic logic [2:0] size_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Byte-lane merge of write data into the 32-bit table address.
  function automatic logic [31:0] addr_merge(logic [31:0] old, logic [31:0] wd,
                                             logic [1:0] lane, logic [2:0] nbytes);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) begin
      int j;
      j = b - int'(lane);
      if (j >= 0 && j < int'(nbytes)) r[8*b +: 8] = wd[8*j +: 8];
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] summary_both(logic [7:0] cmd0, logic [7:0] st0,
                                                 logic [7:0] st1, logic pend0, logic pend1);
    logic [DW-1:0] r;
    r       = {24'h0, cmd0};
    r[4]    = r[4] | pend0;
    r[6]    = r[6] | pend1;
    r[14]   = st1[2];
    r[23:16] = st0;
    r[31:24] = st1;
    return r;
  endfunction

  function automatic logic [DW-1:0] summary_one(logic [7:0] cmd1, logic [7:0] st1, logic pend1);
    logic [DW-1:0] r;
    r        = {24'h0, cmd1};
    r[4]     = r[4] | pend1;
    r[23:16] = st1;
    return r;
  endfunction
endpackage

// File: rtl/regbank_chan.sv
module regbank_chan
  import regbank_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [1:0]        wr_size,
  input  logic [DW-1:0]     wr_data,
  input  logic              dma_busy,
  input  logic              dma_err_set,
  input  logic              dma_int_set,
  input  logic              irq_in,
  output logic [7:0]        cmd_q,
  output logic [7:0]        scratch_q,
  output logic [7:0]        status_q,
  output logic [DW-1:0]     table_q,
  output logic [DW-1:0]     conf_word,
  output logic [LCTL_W-1:0] lctl_q,
  output logic [IEN_W-1:0]  ien_q,
  output logic              irq_pend,
  output logic              reset_fire
);
  localparam logic [OFF_W-1:0] DMA_OFF   = OFF_W'(CH * DMA_STRIDE);
  localparam logic [OFF_W-1:0] CMD_M     = OFF_W'(CH * DMA_STRIDE + MIRROR_GAP);
  localparam logic [OFF_W-1:0] TBL_OFF   = OFF_W'(CH * DMA_STRIDE + 4);
  localparam logic [OFF_W-1:0] LCTL_OFF  = OFF_W'(LINK_BASE + CH * LINK_STRIDE);
  localparam logic [OFF_W-1:0] IEN_OFF   = OFF_W'(LINK_BASE + CH * LINK_STRIDE + IEN_REL);

  logic hit_cmd, hit_scr, hit_st, hit_tbl, hit_lctl, hit_ien;
  logic irq_q;
  logic [7:0] status_d;

  assign hit_cmd  = wr_en && (wr_off == DMA_OFF     || wr_off == CMD_M);
  assign hit_scr  = wr_en && (wr_off == DMA_OFF + 1 || wr_off == CMD_M + 1);
  assign hit_st   = wr_en && (wr_off == DMA_OFF + 2 || wr_off == CMD_M + 2);
  assign hit_tbl  = wr_en && (wr_off[OFF_W-1:2] == TBL_OFF[OFF_W-1:2]);
  assign hit_lctl = wr_en && (wr_off == LCTL_OFF);
  assign hit_ien  = wr_en && (wr_off == IEN_OFF);

  assign reset_fire = hit_lctl && wr_data[0];
  assign irq_pend   = irq_q;
  assign conf_word  = {CONF_HI_RST, 4'h0, irq_q, 11'h000};

  always_comb begin
    status_d = status_q;
    if (hit_st) status_d = status_after_write(status_q, wr_data[7:0]);
    status_d[0] = dma_busy;
    if (dma_err_set) status_d[1] = 1'b1;
    if (dma_int_set) status_d[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      scratch_q <= '0;
      status_q  <= '0;
      table_q   <= '0;
      lctl_q    <= '0;
      ien_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q    <= irq_in;
      status_q <= status_d;
      if (hit_cmd)  cmd_q     <= wr_data[7:0];
      if (hit_scr)  scratch_q <= wr_data[7:0] & SCRATCH_MASK;
      if (hit_tbl)  table_q   <= addr_merge(table_q, wr_data, wr_off[1:0], size_bytes(wr_size));
      if (hit_lctl) lctl_q    <= wr_data[LCTL_W-1:0];
      if (hit_ien)  ien_q     <= wr_data[DW-1:DW-IEN_W] & IEN_MASK;
    end
  end
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
  import regbank_pkg::*;
(
  input  logic [OFF_W-1:0]              rd_off,
  input  logic [NUM_CH-1:0][7:0]        cmd_all,
  input  logic [NUM_CH-1:0][7:0]        scratch_all,
  input  logic [NUM_CH-1:0][7:0]        status_all,
  input  logic [NUM_CH-1:0][DW-1:0]     table_all,
  input  logic [NUM_CH-1:0][DW-1:0]     conf_all,
  input  logic [NUM_CH-1:0][LCTL_W-1:0] lctl_all,
  input  logic [NUM_CH-1:0][IEN_W-1:0]  ien_all,
  input  logic [NUM_CH-1:0]             pend_all,
  input  logic [NUM_CH-1:0]             present,
  output logic [DW-1:0]                 rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_off == OFF_W'(SUM0_OFF))
      rd_data = summary_both(cmd_all[0], status_all[0], status_all[1], pend_all[0], pend_all[1]);
    if (rd_off == OFF_W'(SUM1_OFF))
      rd_data = summary_one(cmd_all[1], status_all[1], pend_all[1]);
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_off == OFF_W'(c * DMA_STRIDE))     rd_data = {24'h0, cmd_all[c]};
      if (rd_off == OFF_W'(c * DMA_STRIDE + 1)) rd_data = {24'h0, scratch_all[c]};
      if (rd_off == OFF_W'(c * DMA_STRIDE + 2)) rd_data = {24'h0, status_all[c]};
      if (rd_off[OFF_W-1:2] == OFF_W'(c * DMA_STRIDE + 4) >> 2)
        rd_data = table_all[c] >> (8 * rd_off[1:0]);
      if (rd_off == OFF_W'(CONF_BASE + c * CONF_STRIDE)) rd_data = conf_all[c];
      if (rd_off == OFF_W'(LINK_BASE + c * LINK_STRIDE))
        rd_data = {{(DW-LCTL_W){1'b0}}, lctl_all[c]};
      if (rd_off == OFF_W'(LINK_BASE + c * LINK_STRIDE + LSTAT_REL))
        rd_data = present[c] ? LINK_UP : '0;
      if (rd_off == OFF_W'(LINK_BASE + c * LINK_STRIDE + IEN_REL))
        rd_data = {ien_all[c], {(DW-IEN_W){1'b0}}};
    end
  end
endmodule

// File: rtl/dual_chan_regbank.sv
module dual_chan_regbank
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [NUM_CH-1:0] dma_busy,
  input  logic [NUM_CH-1:0] dma_err_set,
  input  logic [NUM_CH-1:0] dma_int_set,
  input  logic [NUM_CH-1:0] chan_irq_in,
  input  logic [NUM_CH-1:0] dev_present,
  output logic              irq_out,
  output logic [NUM_CH-1:0] chan_reset
);
  logic wr_en, rd_en;
  logic [NUM_CH-1:0][7:0]        cmd_all, scratch_all, st_all;
  logic [NUM_CH-1:0][DW-1:0]     table_all, conf_all;
  logic [NUM_CH-1:0][LCTL_W-1:0] lctl_all;
  logic [NUM_CH-1:0][IEN_W-1:0]  ien_all;
  logic [NUM_CH-1:0]             pend_all, fire_all;
  logic [DW-1:0]                 rd_comb;

  assign wr_en = req_valid &&  req_write;
  assign rd_en = req_valid && !req_write;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    regbank_chan #(.CH(c)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_off      (req_offset),
      .wr_size     (req_size),
      .wr_data     (req_wdata),
      .dma_busy    (dma_busy[c]),
      .dma_err_set (dma_err_set[c]),
      .dma_int_set (dma_int_set[c]),
      .irq_in      (chan_irq_in[c]),
      .cmd_q       (cmd_all[c]),
      .scratch_q   (scratch_all[c]),
      .status_q    (st_all[c]),
      .table_q     (table_all[c]),
      .conf_word   (conf_all[c]),
      .lctl_q      (lctl_all[c]),
      .ien_q       (ien_all[c]),
      .irq_pend    (pend_all[c]),
      .reset_fire  (fire_all[c])
    );
  end

  regbank_rdmux u_rdmux (
    .rd_off      (req_offset),
    .cmd_all     (cmd_all),
    .scratch_all (scratch_all),
    .status_all  (st_all),
    .table_all   (table_all),
    .conf_all    (conf_all),
    .lctl_all    (lctl_all),
    .ien_all     (ien_all),
    .pend_all    (pend_all),
    .present     (dev_present),
    .rd_data     (rd_comb)
  );

  assign irq_out = |pend_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      chan_reset <= '1;
    end else begin
      rsp_valid  <= rd_en;
      rsp_rdata  <= rd_en ? rd_comb : '0;
      chan_reset <= fire_all;
    end
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [OFF_W-1:0]       req_offset,
  input logic                   wd_bit0,
  input logic                   rsp_valid,
  input logic [NUM_CH-1:0]      dma_busy,
  input logic [NUM_CH-1:0]      dma_int_set,
  input logic [NUM_CH-1:0]      chan_irq_in,
  input logic                   irq_out,
  input logic [NUM_CH-1:0]      chan_reset,
  input logic [NUM_CH-1:0][7:0] st_all
);
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rsp_valid);

  p_no_write_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_all_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_irq_in == '0 |=> !irq_out);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [OFF_W-1:0] LC = OFF_W'(LINK_BASE + c * LINK_STRIDE);

    p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chan_irq_in[c] |=> irq_out);

    p_busy_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dma_busy[c] |=> st_all[c][0]);

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dma_int_set[c] |=> st_all[c][2]);

    p_reset_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && req_offset == LC && wd_bit0 |=> chan_reset[c]);

    p_reset_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write && req_offset == LC && wd_bit0) |=> !chan_reset[c]);
  end
endmodule

bind dual_chan_regbank regbank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_offset  (req_offset),
  .wd_bit0     (req_wdata[0]),
  .rsp_valid   (rsp_valid),
  .dma_busy    (dma_busy),
  .dma_int_set (dma_int_set),
  .chan_irq_in (chan_irq_in),
  .irq_out     (irq_out),
  .chan_reset  (chan_reset),
  .st_all      (st_all)
);

// File: tb/dual_chan_regbank_tb_top.sv
module dual_chan_regbank_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]  req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  dma_busy = '0, dma_err_set = '0, dma_int_set = '0;
  logic [1:0]  chan_irq_in = '0, dev_present = '0;
  logic        irq_out;
  logic [1:0]  chan_reset;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [1:0]  pend_err = '0, pend_int = '0;
  bit          pend_irq_en = 0;
  logic [1:0]  pend_irq_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_chan_regbank dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_op(bit wr, logic [8:0] off, logic [1:0] sz, logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off; req_size = sz; req_wdata = wd;
    dma_err_set = pend_err; dma_int_set = pend_int;
    if (pend_irq_en) chan_irq_in = pend_irq_val;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    dma_err_set = '0; dma_int_set = '0;
    pend_err = '0; pend_int = '0; pend_irq_en = 0;
  endtask

  task automatic wr(logic [8:0] off, logic [1:0] sz, logic [31:0] wd);
    bus_op(1'b1, off, sz, wd);
  endtask

  task automatic rd(logic [8:0] off, logic [1:0] sz, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_op(1'b0, off, sz, '0);
  endtask

  // Monitor: pops one expected item for every read response.
  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected response", {31'h0, rsp_valid}, 32'h0);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R14 pulse after reset", {30'h0, chan_reset}, 32'h3);
    chk("R1 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
    chk("R1 irq_out idle", {31'h0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R14 pulse ends", {30'h0, chan_reset}, 32'h0);

    rd(9'h000, 2'd0, 32'h0, "R1 cmd0");
    rd(9'h002, 2'd0, 32'h0, "R1 status0");
    rd(9'h004, 2'd2, 32'h0, "R1 table0");
    rd(9'h0A0, 2'd2, 32'h6515_0000, "R1 conf0");
    rd(9'h0E0, 2'd2, 32'h6515_0000, "R1 conf1");
    rd(9'h100, 2'd2, 32'h0, "R1 linkctl0");
    rd(9'h1C8, 2'd2, 32'h0, "R1 ien1");

    wr(9'h000, 2'd0, 32'hFFFF_FFA5);
    chk("R2 no response to write", {31'h0, rsp_valid}, 32'h0);
    rd(9'h000, 2'd0, 32'hA5, "R3 cmd0");
    wr(9'h001, 2'd0, 32'h0000_00FF);
    rd(9'h001, 2'd0, 32'h3F, "R3 scratch mask");
    rd(9'h003, 2'd0, 32'h0, "R3 reserved byte");
    wr(9'h004, 2'd2, 32'h1234_5678);
    rd(9'h004, 2'd2, 32'h1234_5678, "R3 table word");
    wr(9'h006, 2'd1, 32'h0000_BEEF);
    rd(9'h004, 2'd2, 32'hBEEF_5678, "R3 table half lane");
    rd(9'h005, 2'd2, 32'h00BE_EF56, "R3 table shifted read");
    wr(9'h007, 2'd2, 32'hAABB_CCDD);
    rd(9'h004, 2'd2, 32'hDDEF_5678, "R3 table clipped");
    rd(9'h00C, 2'd2, 32'h0, "R3 table1 independent");

    wr(9'h018, 2'd0, 32'h21);
    rd(9'h008, 2'd0, 32'h21, "R4 cmd1 mirror");
    wr(9'h019, 2'd0, 32'h7F);
    rd(9'h009, 2'd0, 32'h3F, "R4 scratch1 mirror");
    wr(9'h012, 2'd0, 32'h60);
    rd(9'h002, 2'd0, 32'h60, "R4 status0 mirror");
    rd(9'h011, 2'd0, 32'h0, "R4 mirror read zero");

    wr(9'h040, 2'd2, 32'hFFFF_FFFF);
    rd(9'h040, 2'd2, 32'h0, "R2 unmapped");
    wr(9'h0A0, 2'd2, 32'h0);
    rd(9'h0A0, 2'd2, 32'h6515_0000, "R7 conf read-only");

    dma_busy = 2'b01;
    pend_err = 2'b01; pend_int = 2'b01;
    wr(9'h044, 2'd0, 32'h0);
    rd(9'h002, 2'd0, 32'h67, "R6 set pulses and busy");
    wr(9'h002, 2'd0, 32'h9B);
    rd(9'h002, 2'd0, 32'h05, "R5 status write merge");
    pend_int = 2'b01;
    wr(9'h002, 2'd0, 32'h04);
    rd(9'h002, 2'd0, 32'h05, "R6 set beats clear");
    wr(9'h002, 2'd0, 32'h06);
    rd(9'h002, 2'd0, 32'h01, "R5 w1c clears");
    dma_busy = 2'b00;
    @(negedge clk);
    rd(9'h002, 2'd0, 32'h00, "R6 busy follows");

    pend_int = 2'b10;
    wr(9'h00A, 2'd0, 32'h20);
    rd(9'h00A, 2'd0, 32'h24, "R5 status1");

    chan_irq_in = 2'b10;
    @(negedge clk);
    chk("R8 irq_out ch1", {31'h0, irq_out}, 32'h1);
    rd(9'h0E0, 2'd2, 32'h6515_0800, "R7 conf1 pending");
    rd(9'h0A0, 2'd2, 32'h6515_0000, "R7 conf0 idle");
    pend_irq_en = 1; pend_irq_val = 2'b11;
    rd(9'h010, 2'd2, 32'h2400_40E5, "R9 summary same-cycle edge");
    rd(9'h010, 2'd2, 32'h2400_40F5, "R9 summary both pending");
    rd(9'h018, 2'd2, 32'h0024_0031, "R10 summary ch1");
    chan_irq_in = 2'b01;
    @(negedge clk);
    chk("R8 irq_out ch0 only", {31'h0, irq_out}, 32'h1);
    chan_irq_in = 2'b00;
    @(negedge clk);
    chk("R8 irq_out cleared", {31'h0, irq_out}, 32'h0);

    wr(9'h100, 2'd2, 32'hFFFF_F001);
    chk("R11 reset pulse ch0", {30'h0, chan_reset}, 32'h1);
    @(negedge clk);
    chk("R11 reset pulse one cycle", {30'h0, chan_reset}, 32'h0);
    rd(9'h100, 2'd2, 32'h001, "R11 linkctl0 mask");
    wr(9'h180, 2'd2, 32'h0000_0ABC);
    chk("R11 no pulse bit0 clear", {30'h0, chan_reset}, 32'h0);
    rd(9'h180, 2'd2, 32'hABC, "R11 linkctl1");

    wr(9'h148, 2'd2, 32'hFFFF_1234);
    rd(9'h148, 2'd2, 32'h3EED_0000, "R12 ien0 mask");
    wr(9'h1C8, 2'd2, 32'h1234_FFFF);
    rd(9'h1C8, 2'd2, 32'h1224_0000, "R12 ien1");

    rd(9'h104, 2'd2, 32'h0, "R13 link0 absent");
    dev_present = 2'b10;
    rd(9'h184, 2'd2, 32'h113, "R13 link1 present");
    rd(9'h104, 2'd2, 32'h0, "R13 link0 still absent");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", exp_q.size(), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule